// File: doc/BRIEF.md
# DMA Transfer Splitting Arbiter

This block sits between a set of DMA channels and a request engine. Each channel holds one queued command, made of a start address and a total byte count. The channel's command logic cuts that command into bus-sized chunks as the command runs. A chunk is never larger than the configured maximum payload or request size, and never larger than the bytes still owed. The channel offers a chunk only when the data amount it advertises covers that chunk. For the receive direction, the advertised amount is the free space in the channel. This gives back pressure on each transfer without stalling the shared engine.

The channels that can start a transfer form a request vector. A separate arbitration module turns that vector into a one-hot grant. The module is selected by a parameter: a fixed lowest-index-first encoder by default, or rotating priority. The granted chunk's address and length go to the request engine through a valid/ready handshake. The channel's address and remaining count then advance by the chunk length. The grant is held until the engine reports the chunk done, and the granted channel's data is steered onto the outgoing data bus. A new chunk may be issued in the same cycle that the engine reports the previous one done. A full-duplex link uses two instances of the block, one for sends and one for receives.

Top module: `dma_split_arb`

## Requirements
- R1: After reset, req_valid_o is 0, gnt_o is 0, cmd_done_o is 0 and every cmd_ready_o bit is 1.
- R2: cmd_ready_o[i] is 1 exactly when channel i holds no command. A command is taken when cmd_valid_o and cmd_ready_o are both 1. Bits [1:0] of the size are ignored, so sizes count 4-byte words. A command whose size is 0 after that masking is dropped, and the channel stays ready.
- R3: The offered chunk length is min(MAX_CHUNK, remaining bytes). It is never 0, and the first chunk of a command starts at the command's start address.
- R4: Each issued chunk (req_valid_o and req_ready_i both 1) advances the channel's next address by the chunk length and reduces its remaining bytes by the same amount.
- R5: A channel takes part in arbitration only while its advertised amount chan_avail_i is at least the length of its next chunk.
- R6: With POLICY=0 the lowest-numbered requesting channel wins. req_chan_o gives the binary index of the winner.
- R7: With POLICY=1 the search starts at the channel after the last one that issued, so channels with continuous requests are served in rotating order.
- R8: The arbiter's grant is one-hot and a subset of the request vector. From an issue until req_done_i, gnt_o holds the issued channel's one-hot value and req_valid_o stays 0.
- R9: When req_done_i is 1, the next chunk can be offered and issued in that same cycle, with no idle cycle between chunks.
- R10: cmd_done_o[i] pulses for exactly one cycle, in the cycle after the issue of the command's last chunk. In that same cycle cmd_ready_o[i] returns to 1.
- R11: While a chunk is outstanding, req_data_o equals the data lane of the channel in gnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | NCH | Per-channel command offer |
| cmd_addr_i | input | NCH*AW | Per-channel start address |
| cmd_size_i | input | NCH*SW | Per-channel total byte count |
| cmd_ready_o | output | NCH | Channel has no command and can take one |
| chan_avail_i | input | NCH*SW | Bytes each channel can currently supply or accept |
| chan_data_i | input | NCH*DW | Per-channel data lanes |
| cmd_done_o | output | NCH | One-cycle pulse when a command's last chunk is issued |
| req_valid_o | output | 1 | A chunk is offered to the request engine |
| req_ready_i | input | 1 | Request engine takes the offered chunk |
| req_addr_o | output | AW | Address of the offered chunk |
| req_len_o | output | LW | Byte length of the offered chunk |
| req_chan_o | output | IW | Index of the offering channel |
| req_done_i | input | 1 | Request engine has finished the outstanding chunk |
| gnt_o | output | NCH | One-hot channel owning the outstanding chunk |
| req_data_o | output | DW | Data lane of the channel in gnt_o |

## Verification
The hardest case to reach from the ports is the cycle in which the engine reports one chunk done and, on the same clock edge, takes the next chunk. The outstanding grant, the channel's updated address and the completion pulse all meet in that cycle. The stimulus holds req_done_i and req_ready_i high together, while a two-chunk command waits behind its own outstanding first chunk. The bench then checks that the second chunk's address appears at once and that the completion pulse follows one cycle later. Rotating priority can only be seen with several channels that keep requesting, so a second instance with the other policy gets three two-chunk commands at once.

// File: rtl/dma_split_pkg.sv
package dma_split_pkg;

  // Length of the next chunk: the smaller of what is left and the cap.
  function automatic logic [31:0] chunk_of(input logic [31:0] rem, input logic [31:0] cap);
    return (rem > cap) ? cap : rem;
  endfunction

  // Binary index of the set bit of a one-hot vector (0 when empty).
  function automatic logic [31:0] onehot_idx(input logic [31:0] oh);
    logic [31:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      if (oh[i]) r = r | 32'(i);
    end
    return r;
  endfunction

  // Rotating pick: first requester after position last, wrapping.
  function automatic logic [31:0] rotate_pick(input logic [31:0] req, input int last, input int n);
    logic [31:0] g;
    logic        found;
    g = '0;
    found = 1'b0;
    for (int k = 1; k <= 32; k++) begin
      if (k <= n) begin
        int idx;
        idx = (last + k) % n;
        if (!found && req[idx]) begin
          g[idx] = 1'b1;
          found = 1'b1;
        end
      end
    end
    return g;
  endfunction

endpackage

// File: rtl/dma_chan_cmd.sv
module dma_chan_cmd
  import dma_split_pkg::*;
#(
  parameter int AW        = 32,
  parameter int SW        = 16,
  parameter int MAX_CHUNK = 256,
  parameter int LW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  input  logic [SW-1:0] cmd_size,
  output logic          cmd_ready,
  input  logic [SW-1:0] avail,
  input  logic          take,
  output logic          req_ok,
  output logic [AW-1:0] nxt_addr,
  output logic [LW-1:0] nxt_len,
  output logic          done_pulse
);

  logic          pend_q;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] rem_q;
  logic          done_q;
  logic [SW-1:0] size_w;
  logic          load;

  assign size_w    = cmd_size & ~SW'(3);
  assign cmd_ready = !pend_q;
  assign load      = cmd_valid && !pend_q && (size_w != '0);

  assign nxt_len   = LW'(chunk_of(32'(rem_q), 32'(MAX_CHUNK)));
  assign nxt_addr  = addr_q;
  assign req_ok    = pend_q && (avail >= SW'(nxt_len));
  assign done_pulse = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        pend_q <= 1'b1;
        addr_q <= cmd_addr;
        rem_q  <= size_w;
      end else if (take && pend_q) begin
        addr_q <= addr_q + AW'(nxt_len);
        rem_q  <= rem_q - SW'(nxt_len);
        if (rem_q == SW'(nxt_len)) begin
          pend_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dma_arb_policy.sv
module dma_arb_policy
  import dma_split_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int POLICY = 0
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] req_vec,
  input  logic           advance,
  output logic [NCH-1:0] gnt
);

  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

  generate
    if (POLICY == 0) begin : g_fixed
      always_comb begin
        gnt = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
          if (req_vec[i]) gnt = NCH'(1) << i;
        end
      end
    end else begin : g_rotate
      logic [IW-1:0] last_q;
      always_comb gnt = NCH'(rotate_pick(32'(req_vec), int'(last_q), NCH));
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          last_q <= IW'(NCH - 1);
        end else if (advance && (gnt != '0)) begin
          last_q <= IW'(onehot_idx(32'(gnt)));
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dma_data_mux.sv
module dma_data_mux #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic [NCH-1:0]    sel,
  input  logic [NCH*DW-1:0] lanes,
  output logic [DW-1:0]     out
);

  always_comb begin
    out = '0;
    for (int i = 0; i < NCH; i++) begin
      out = out | (lanes[i*DW +: DW] & {DW{sel[i]}});
    end
  end

endmodule

// File: rtl/dma_split_arb.sv
module dma_split_arb
  import dma_split_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int AW        = 32,
  parameter int SW        = 16,
  parameter int DW        = 32,
  parameter int MAX_CHUNK = 256,
  parameter int POLICY    = 0,
  parameter int LW        = $clog2(MAX_CHUNK) + 1,
  parameter int IW        = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    cmd_valid_i,
  input  logic [NCH*AW-1:0] cmd_addr_i,
  input  logic [NCH*SW-1:0] cmd_size_i,
  output logic [NCH-1:0]    cmd_ready_o,
  input  logic [NCH*SW-1:0] chan_avail_i,
  input  logic [NCH*DW-1:0] chan_data_i,
  output logic [NCH-1:0]    cmd_done_o,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_addr_o,
  output logic [LW-1:0]     req_len_o,
  output logic [IW-1:0]     req_chan_o,
  input  logic              req_done_i,
  output logic [NCH-1:0]    gnt_o,
  output logic [DW-1:0]     req_data_o
);

  logic [NCH-1:0]    valid_vec;
  logic [NCH-1:0]    arb_gnt;
  logic [NCH-1:0]    take;
  logic [NCH*AW-1:0] ch_addr;
  logic [NCH*LW-1:0] ch_len;
  logic [NCH-1:0]    grant_q;
  logic              busy_q;
  logic              free_w;
  logic              issue;
  logic [SW-1:0]     iss_avail;

  genvar gi;
  generate
    for (gi = 0; gi < NCH; gi++) begin : g_ch
      dma_chan_cmd #(
        .AW(AW), .SW(SW), .MAX_CHUNK(MAX_CHUNK), .LW(LW)
      ) u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid_i[gi]),
        .cmd_addr   (cmd_addr_i[gi*AW +: AW]),
        .cmd_size   (cmd_size_i[gi*SW +: SW]),
        .cmd_ready  (cmd_ready_o[gi]),
        .avail      (chan_avail_i[gi*SW +: SW]),
        .take       (take[gi]),
        .req_ok     (valid_vec[gi]),
        .nxt_addr   (ch_addr[gi*AW +: AW]),
        .nxt_len    (ch_len[gi*LW +: LW]),
        .done_pulse (cmd_done_o[gi])
      );
      assign take[gi] = issue && arb_gnt[gi];
    end
  endgenerate

  dma_arb_policy #(.NCH(NCH), .POLICY(POLICY)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_vec (valid_vec),
    .advance (issue),
    .gnt     (arb_gnt)
  );

  assign free_w      = !busy_q || req_done_i;
  assign req_valid_o = free_w && (valid_vec != '0);
  assign issue       = req_valid_o && req_ready_i;

  always_comb begin
    req_addr_o = '0;
    req_len_o  = '0;
    iss_avail  = '0;
    for (int i = 0; i < NCH; i++) begin
      if (arb_gnt[i]) begin
        req_addr_o = req_addr_o | ch_addr[i*AW +: AW];
        req_len_o  = req_len_o  | ch_len[i*LW +: LW];
        iss_avail  = iss_avail  | chan_avail_i[i*SW +: SW];
      end
    end
  end

  assign req_chan_o = IW'(onehot_idx(32'(arb_gnt)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
    end else if (issue) begin
      busy_q  <= 1'b1;
      grant_q <= arb_gnt;
    end else if (req_done_i) begin
      busy_q  <= 1'b0;
      grant_q <= '0;
    end
  end

  assign gnt_o = grant_q;

  dma_data_mux #(.NCH(NCH), .DW(DW)) u_mux (
    .sel   (grant_q),
    .lanes (chan_data_i),
    .out   (req_data_o)
  );

endmodule

// File: rtl/dma_split_chk.sv
module dma_split_chk #(
  parameter int NCH       = 4,
  parameter int SW        = 16,
  parameter int LW        = 9,
  parameter int MAX_CHUNK = 256
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] valid_vec,
  input logic [NCH-1:0] arb_gnt,
  input logic [NCH-1:0] grant_q,
  input logic           busy_q,
  input logic           req_valid,
  input logic [LW-1:0]  req_len,
  input logic [SW-1:0]  iss_avail,
  input logic           req_done,
  input logic           issue
);

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(arb_gnt)); // R8
  AST_GNT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n) (arb_gnt & ~valid_vec) == '0); // R8
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (32'(req_len) <= MAX_CHUNK)); // R3
  AST_AVAIL_COVER: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> iss_avail >= SW'(req_len)); // R5
  AST_HOLD_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !req_done) |=> busy_q && $stable(grant_q)); // R8
  AST_QUIET_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !req_done) |-> !req_valid); // R8
  AST_ISSUE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> busy_q && (grant_q == $past(arb_gnt))); // R9

endmodule

bind dma_split_arb dma_split_chk #(
  .NCH(NCH), .SW(SW), .LW(LW), .MAX_CHUNK(MAX_CHUNK)
) u_split_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .valid_vec (valid_vec),
  .arb_gnt   (arb_gnt),
  .grant_q   (grant_q),
  .busy_q    (busy_q),
  .req_valid (req_valid_o),
  .req_len   (req_len_o),
  .iss_avail (iss_avail),
  .req_done  (req_done_i),
  .issue     (issue)
);

// File: tb/test_dma_split_arb.sv
module test_dma_split_arb;

  localparam int NCH = 4;
  localparam int AW  = 32;
  localparam int SW  = 16;
  localparam int DW  = 32;
  localparam int MAXC = 256;
  localparam int LW  = 9;
  localparam int IW  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NCH-1:0]    cmd_valid;
  logic [NCH*AW-1:0] cmd_addr;
  logic [NCH*SW-1:0] cmd_size;
  logic [NCH-1:0]    cmd_ready;
  logic [NCH*SW-1:0] avail;
  logic [NCH*DW-1:0] cdata;
  logic [NCH-1:0]    cmd_done;
  logic              req_valid, req_ready, req_done;
  logic [AW-1:0]     req_addr;
  logic [LW-1:0]     req_len;
  logic [IW-1:0]     req_chan;
  logic [NCH-1:0]    gnt;
  logic [DW-1:0]     req_data;

  logic [NCH-1:0]    rr_cmd_valid;
  logic [NCH*AW-1:0] rr_cmd_addr;
  logic [NCH*SW-1:0] rr_cmd_size;
  logic [NCH-1:0]    rr_cmd_ready;
  logic [NCH-1:0]    rr_cmd_done;
  logic              rr_valid, rr_ready, rr_done;
  logic [AW-1:0]     rr_addr;
  logic [LW-1:0]     rr_len;
  logic [IW-1:0]     rr_chan;
  logic [NCH-1:0]    rr_gnt;
  logic [DW-1:0]     rr_data;

  dma_split_arb #(.NCH(NCH), .AW(AW), .SW(SW), .DW(DW), .MAX_CHUNK(MAXC), .POLICY(0)) i_dma_split_arb (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_addr_i(cmd_addr), .cmd_size_i(cmd_size),
    .cmd_ready_o(cmd_ready), .chan_avail_i(avail), .chan_data_i(cdata), .cmd_done_o(cmd_done),
    .req_valid_o(req_valid), .req_ready_i(req_ready), .req_addr_o(req_addr), .req_len_o(req_len),
    .req_chan_o(req_chan), .req_done_i(req_done), .gnt_o(gnt), .req_data_o(req_data));

  dma_split_arb #(.NCH(NCH), .AW(AW), .SW(SW), .DW(DW), .MAX_CHUNK(MAXC), .POLICY(1)) i_dma_split_arb_rr (
    .clk(clk), .rst_n(rst_n), .cmd_valid_i(rr_cmd_valid), .cmd_addr_i(rr_cmd_addr), .cmd_size_i(rr_cmd_size),
    .cmd_ready_o(rr_cmd_ready), .chan_avail_i(avail), .chan_data_i(cdata), .cmd_done_o(rr_cmd_done),
    .req_valid_o(rr_valid), .req_ready_i(rr_ready), .req_addr_o(rr_addr), .req_len_o(rr_len),
    .req_chan_o(rr_chan), .req_done_i(rr_done), .gnt_o(rr_gnt), .req_data_o(rr_data));

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic set_cmd(input int ch, input logic [31:0] addr, input logic [15:0] size);
    cmd_valid[ch] = 1'b1;
    cmd_addr[ch*AW +: AW] = addr;
    cmd_size[ch*SW +: SW] = size;
  endtask

  task automatic commit_cmds();
    @(posedge clk);
    @(negedge clk);
    cmd_valid = '0;
  endtask

  // Issue one chunk, then complete it with a separate done pulse.
  task automatic issue_chunk(input int ch, input logic [31:0] addr, input int len, input bit last);
    @(negedge clk);
    req_ready = 1'b1;
    #1;
    chk(req_valid == 1'b1, "R3 offer", 64'(req_valid), 64'd1);
    chk(req_addr == addr, "R4 addr", 64'(req_addr), 64'(addr));
    chk(req_len == LW'(len), "R3 len", 64'(req_len), 64'(len));
    chk(req_chan == IW'(ch), "R6 chan", 64'(req_chan), 64'(ch));
    @(posedge clk);
    @(negedge clk);
    req_ready = 1'b0;
    #1;
    chk(gnt == NCH'(1 << ch), "R8 gnt hold", 64'(gnt), 64'(1 << ch));
    chk(req_valid == 1'b0, "R8 quiet", 64'(req_valid), 64'd0);
    chk(req_data == DW'(32'hD000_0000 + ch), "R11 data", 64'(req_data), 64'(32'hD000_0000 + ch));
    chk(cmd_done[ch] == last, "R10 done", 64'(cmd_done[ch]), 64'(last));
    req_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_done = 1'b0;
    #1;
    chk(gnt == '0, "R8 release", 64'(gnt), 64'd0);
    chk(cmd_done == '0, "R10 one cycle", 64'(cmd_done), 64'd0);
  endtask

  task automatic t_reset();
    #1;
    chk(req_valid == 1'b0, "R1 req_valid", 64'(req_valid), 64'd0);
    chk(gnt == '0, "R1 gnt", 64'(gnt), 64'd0);
    chk(cmd_done == '0, "R1 done", 64'(cmd_done), 64'd0);
    chk(cmd_ready == '1, "R1 ready", 64'(cmd_ready), 64'hF);
  endtask

  task automatic t_split();
    @(negedge clk);
    set_cmd(1, 32'h1000, 16'd600);
    commit_cmds();
    #1;
    chk(cmd_ready[1] == 1'b0, "R2 busy chan", 64'(cmd_ready[1]), 64'd0);
    issue_chunk(1, 32'h1000, 256, 1'b0);
    issue_chunk(1, 32'h1100, 256, 1'b0);
    issue_chunk(1, 32'h1200, 88, 1'b1);
    chk(cmd_ready[1] == 1'b1, "R10 ready again", 64'(cmd_ready[1]), 64'd1);
  endtask

  task automatic t_back_to_back();
    @(negedge clk);
    set_cmd(0, 32'h2000, 16'd512);
    commit_cmds();
    req_ready = 1'b1;
    #1;
    chk(req_addr == 32'h2000, "R3 start", 64'(req_addr), 64'h2000);
    @(posedge clk);
    @(negedge clk);
    req_ready = 1'b1;
    req_done  = 1'b1;
    #1;
    chk(req_valid == 1'b1, "R9 same cycle offer", 64'(req_valid), 64'd1);
    chk(req_addr == 32'h2100, "R9 next addr", 64'(req_addr), 64'h2100);
    @(posedge clk);
    @(negedge clk);
    req_ready = 1'b0;
    req_done  = 1'b0;
    #1;
    chk(gnt == 4'b0001, "R9 regrant", 64'(gnt), 64'd1);
    chk(cmd_done[0] == 1'b1, "R10 pulse", 64'(cmd_done[0]), 64'd1);
    req_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_done = 1'b0;
    #1;
    chk(gnt == '0, "R8 release b2b", 64'(gnt), 64'd0);
  endtask

  task automatic t_avail_gate();
    @(negedge clk);
    avail[2*SW +: SW] = 16'd64;
    set_cmd(2, 32'h3000, 16'd128);
    commit_cmds();
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(req_valid == 1'b0, "R5 held back", 64'(req_valid), 64'd0);
      @(negedge clk);
    end
    avail[2*SW +: SW] = 16'd128;
    #1;
    chk(req_valid == 1'b1, "R5 released", 64'(req_valid), 64'd1);
    issue_chunk(2, 32'h3000, 128, 1'b1);
    avail[2*SW +: SW] = 16'hFFFF;
  endtask

  task automatic t_size_mask();
    @(negedge clk);
    set_cmd(3, 32'h5000, 16'd0);
    commit_cmds();
    #1;
    chk(cmd_ready[3] == 1'b1, "R2 zero dropped", 64'(cmd_ready[3]), 64'd1);
    chk(req_valid == 1'b0, "R2 zero no req", 64'(req_valid), 64'd0);
    @(negedge clk);
    set_cmd(3, 32'h4000, 16'h0043);
    commit_cmds();
    issue_chunk(3, 32'h4000, 32'h40, 1'b1);
  endtask

  task automatic t_priority();
    @(negedge clk);
    set_cmd(3, 32'h6000, 16'd64);
    set_cmd(1, 32'h7000, 16'd64);
    commit_cmds();
    issue_chunk(1, 32'h7000, 64, 1'b1);
    issue_chunk(3, 32'h6000, 64, 1'b1);
  endtask

  task automatic t_round_robin();
    @(negedge clk);
    for (int c = 0; c < 3; c++) begin
      rr_cmd_valid[c] = 1'b1;
      rr_cmd_addr[c*AW +: AW] = 32'h8000 + 32'(c) * 32'h1000;
      rr_cmd_size[c*SW +: SW] = 16'd512;
    end
    @(posedge clk);
    @(negedge clk);
    rr_cmd_valid = '0;
    for (int k = 0; k < 6; k++) begin
      rr_ready = 1'b1;
      #1;
      chk(rr_valid == 1'b1, "R7 offer", 64'(rr_valid), 64'd1);
      chk(rr_chan == IW'(k % 3), "R7 order", 64'(rr_chan), 64'(k % 3));
      @(posedge clk);
      @(negedge clk);
      rr_ready = 1'b0;
      rr_done  = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rr_done  = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    cmd_valid = '0; cmd_addr = '0; cmd_size = '0;
    rr_cmd_valid = '0; rr_cmd_addr = '0; rr_cmd_size = '0;
    req_ready = 1'b0; req_done = 1'b0; rr_ready = 1'b0; rr_done = 1'b0;
    avail = {NCH{16'hFFFF}};
    for (int i = 0; i < NCH; i++) cdata[i*DW +: DW] = 32'hD000_0000 + 32'(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_split();
    t_back_to_back();
    t_avail_gate();
    t_size_mask();
    t_priority();
    t_round_robin();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule